// File: doc/BRIEF.md
# Delay-slot program counter sequencer

This block keeps the fetch-address state of a processor that uses fixed-width instructions and a single branch delay slot. It also keeps a micro-operation counter for instructions that run as several internal steps. The registered state has five fields: the current instruction address, the following address, the address after that, the current micro-step index and the index of the next micro-step.

Each cycle the block takes one of these commands. Load starts a new stream at an address. Micro-step moves to the next micro-operation. Retire ends the instruction and shifts the address pipeline. Target writes a branch destination into the third address slot, so the delay-slot instruction in the second slot still runs. A micro-target writes a new value into the next micro-step index.

The block drives the current address, the current micro-step index and a non-sequential flag. A comparator checks all five state fields against a state the caller supplies. Addresses wrap modulo 2^ADDR_W. Micro-step indices are 16 bits wide and wrap modulo 2^16.

Top module: `pc_delay_seq`

## Requirements
- R1: When `cmd_load` is high at a clock edge, the state after that edge is: current = A, following = A+W, third = A+2W, micro = 0 and next micro = 1. Here A is `load_addr` and W is INSN_BYTES (default 4). All additions are modulo 2^ADDR_W.
- R2: When `rst` is high at a clock edge, the block takes the R1 state with A = RESET_VEC (default 0x0000_1000), whatever the command inputs are.
- R3: A micro-step sets micro to the old next-micro value and sets next-micro to the old next-micro + 1, modulo 2^16. The three addresses do not change.
- R4: A retire sets current to the old following address and following to the old third address. It sets third to the old third + W, micro to 0 and next-micro to 1.
- R5: A target command loads `redir_addr` into the third address only. A micro-target command loads `ujmp_tgt` into next-micro only. Both may be applied in the same cycle.
- R6: The address part of `branching` is clear only when third == following + W and following is either current + W or current + 2W.
- R7: `branching` is also set whenever next-micro != micro + 1, computed modulo 2^16. It is high when either the R6 condition or this condition is violated.
- R8: `state_match` is high exactly when all five fields equal the five `cmp_*` inputs. A difference in any single field makes it low.
- R9: When several commands are high together, load wins over retire, and retire wins over micro-step. Micro-step wins over target and micro-target, which apply only when no higher command is high.
- R10: With no command high, every state field holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_load | input | 1 | Start a new stream at `load_addr` |
| cmd_retire | input | 1 | End the instruction and shift the addresses |
| cmd_ustep | input | 1 | Advance to the next micro-step |
| cmd_target | input | 1 | Load `redir_addr` into the third address |
| cmd_utarget | input | 1 | Load `ujmp_tgt` into the next micro-step index |
| load_addr | input | ADDR_W | Address used by the load command |
| redir_addr | input | ADDR_W | Branch destination for the third address |
| ujmp_tgt | input | 16 | Next micro-step value for the micro-target command |
| cmp_cur | input | ADDR_W | Comparison value for the current address |
| cmp_nxt | input | ADDR_W | Comparison value for the following address |
| cmp_nnx | input | ADDR_W | Comparison value for the third address |
| cmp_upc | input | 16 | Comparison value for the micro-step index |
| cmp_nupc | input | 16 | Comparison value for the next micro-step index |
| cur_addr | output | ADDR_W | Current instruction address |
| cur_upc | output | 16 | Current micro-step index |
| branching | output | 1 | Non-sequential state flag |
| state_match | output | 1 | All five fields equal the `cmp_*` inputs |

## Verification
A wrong value in the following or third address does not reach `cur_addr` until one or two retires later. It does show at once on `state_match` and usually on `branching`. For that reason every step of the bench drives the comparison inputs with the full expected state, in the same cycle the state is registered. A wrong next-micro value is caught the same way: it shows on `state_match` and on `branching` right after the edge, and on `cur_upc` one micro-step later. The wrap of the micro-step index at 16 bits is checked by stepping across it, because the register can only be reached through micro-steps.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;

    localparam int UPC_W = 16;

    typedef logic [UPC_W-1:0] upc_t;

    typedef struct packed {
        logic load;
        logic retire;
        logic ustep;
        logic target;
        logic utarget;
    } cmd_t;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_LOAD,
        ACT_RETIRE,
        ACT_USTEP,
        ACT_TGT
    } act_e;

endpackage

// File: rtl/pc_seq_arbiter.sv
module pc_seq_arbiter
    import pc_seq_pkg::*;
(
    input  cmd_t cmd,
    output act_e act
);

    always_comb begin
        if (cmd.load)
            act = ACT_LOAD;
        else if (cmd.retire)
            act = ACT_RETIRE;
        else if (cmd.ustep)
            act = ACT_USTEP;
        else if (cmd.target || cmd.utarget)
            act = ACT_TGT;
        else
            act = ACT_HOLD;
    end

    // R9: at most one action is picked, and a load always wins
    always_comb begin
        if (cmd.load)
            AST_LOAD_WINS: assert (act == ACT_LOAD); // R9
    end

endmodule

// File: rtl/pc_seq_next.sv
module pc_seq_next
    import pc_seq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int INSN_BYTES = 4
) (
    input  act_e              act,
    input  logic              do_target,
    input  logic              do_utarget,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [ADDR_W-1:0] redir_addr,
    input  upc_t              ujmp_tgt,
    input  logic [ADDR_W-1:0] cur_q,
    input  logic [ADDR_W-1:0] nxt_q,
    input  logic [ADDR_W-1:0] nnx_q,
    input  upc_t              upc_q,
    input  upc_t              nupc_q,
    output logic [ADDR_W-1:0] cur_d,
    output logic [ADDR_W-1:0] nxt_d,
    output logic [ADDR_W-1:0] nnx_d,
    output upc_t              upc_d,
    output upc_t              nupc_d
);

    localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(INSN_BYTES);
    localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2 * INSN_BYTES);

    typedef struct packed {
        logic [ADDR_W-1:0] cur;
        logic [ADDR_W-1:0] nxt;
        logic [ADDR_W-1:0] nnx;
        upc_t              upc;
        upc_t              nupc;
    } fields_t;

    fields_t nx_d;

    always_comb begin
        nx_d = '{cur: cur_q, nxt: nxt_q, nnx: nnx_q, upc: upc_q, nupc: nupc_q};
        unique case (act)
            ACT_LOAD: begin
                nx_d.cur  = load_addr;
                nx_d.nxt  = load_addr + STEP1;
                nx_d.nnx  = load_addr + STEP2;
                nx_d.upc  = '0;
                nx_d.nupc = upc_t'(1);
            end
            ACT_RETIRE: begin
                nx_d.cur  = nxt_q;
                nx_d.nxt  = nnx_q;
                nx_d.nnx  = nnx_q + STEP1;
                nx_d.upc  = '0;
                nx_d.nupc = upc_t'(1);
            end
            ACT_USTEP: begin
                nx_d.upc  = nupc_q;
                nx_d.nupc = nupc_q + upc_t'(1);
            end
            ACT_TGT: begin
                if (do_target)
                    nx_d.nnx = redir_addr;
                if (do_utarget)
                    nx_d.nupc = ujmp_tgt;
            end
            default: ;
        endcase
    end

    assign cur_d  = nx_d.cur;
    assign nxt_d  = nx_d.nxt;
    assign nnx_d  = nx_d.nnx;
    assign upc_d  = nx_d.upc;
    assign nupc_d = nx_d.nupc;

endmodule

// File: rtl/pc_seq_branch.sv
module pc_seq_branch
    import pc_seq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic [ADDR_W-1:0] cur_q,
    input  logic [ADDR_W-1:0] nxt_q,
    input  logic [ADDR_W-1:0] nnx_q,
    input  upc_t              upc_q,
    input  upc_t              nupc_q,
    output logic              branching
);

    localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(INSN_BYTES);
    localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2 * INSN_BYTES);

    logic [ADDR_W-1:0] nxt_plus1;
    logic [ADDR_W-1:0] cur_plus1;
    logic [ADDR_W-1:0] cur_plus2;
    upc_t              upc_plus1;
    logic              third_seq;
    logic              second_ok;
    logic              micro_seq;

    always_comb begin
        nxt_plus1 = nxt_q + STEP1;
        cur_plus1 = cur_q + STEP1;
        cur_plus2 = cur_q + STEP2;
        upc_plus1 = upc_q + upc_t'(1);
        third_seq = (nnx_q == nxt_plus1);
        second_ok = (nxt_q == cur_plus1) || (nxt_q == cur_plus2);
        micro_seq = (nupc_q == upc_plus1);
        branching = !(third_seq && second_ok && micro_seq);
    end

    // R7: a broken micro-step sequence always shows as a branch
    always_comb begin
        if (nupc_q != upc_plus1)
            AST_MICRO_FLAG: assert (branching); // R7
    end

endmodule

// File: rtl/pc_seq_match.sv
module pc_seq_match
    import pc_seq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur_q,
    input  logic [ADDR_W-1:0] nxt_q,
    input  logic [ADDR_W-1:0] nnx_q,
    input  upc_t              upc_q,
    input  upc_t              nupc_q,
    input  logic [ADDR_W-1:0] cmp_cur,
    input  logic [ADDR_W-1:0] cmp_nxt,
    input  logic [ADDR_W-1:0] cmp_nnx,
    input  upc_t              cmp_upc,
    input  upc_t              cmp_nupc,
    output logic              state_match
);

    localparam int NADDR = 3;
    localparam int NUPC  = 2;

    logic [NADDR-1:0][ADDR_W-1:0] addr_mine;
    logic [NADDR-1:0][ADDR_W-1:0] addr_ref;
    logic [NUPC-1:0][UPC_W-1:0]   upc_mine;
    logic [NUPC-1:0][UPC_W-1:0]   upc_ref;
    logic [NADDR-1:0]             addr_eq;
    logic [NUPC-1:0]              upc_eq;

    assign addr_mine = {cur_q, nxt_q, nnx_q};
    assign addr_ref  = {cmp_cur, cmp_nxt, cmp_nnx};
    assign upc_mine  = {upc_q, nupc_q};
    assign upc_ref   = {cmp_upc, cmp_nupc};

    for (genvar g = 0; g < NADDR; g++) begin : g_addr_eq
        assign addr_eq[g] = (addr_mine[g] == addr_ref[g]);
    end

    for (genvar g = 0; g < NUPC; g++) begin : g_upc_eq
        assign upc_eq[g] = (upc_mine[g] == upc_ref[g]);
    end

    assign state_match = (&addr_eq) && (&upc_eq);

endmodule

// File: rtl/pc_delay_seq.sv
module pc_delay_seq
    import pc_seq_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                INSN_BYTES = 4,
    parameter logic [ADDR_W-1:0] RESET_VEC  = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_load,
    input  logic              cmd_retire,
    input  logic              cmd_ustep,
    input  logic              cmd_target,
    input  logic              cmd_utarget,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [ADDR_W-1:0] redir_addr,
    input  logic [UPC_W-1:0]  ujmp_tgt,
    input  logic [ADDR_W-1:0] cmp_cur,
    input  logic [ADDR_W-1:0] cmp_nxt,
    input  logic [ADDR_W-1:0] cmp_nnx,
    input  logic [UPC_W-1:0]  cmp_upc,
    input  logic [UPC_W-1:0]  cmp_nupc,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [UPC_W-1:0]  cur_upc,
    output logic              branching,
    output logic              state_match
);

    localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(INSN_BYTES);
    localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2 * INSN_BYTES);

    typedef struct packed {
        logic [ADDR_W-1:0] cur;
        logic [ADDR_W-1:0] nxt;
        logic [ADDR_W-1:0] nnx;
        upc_t              upc;
        upc_t              nupc;
    } state_t;

    localparam state_t RST_STATE = '{
        cur:  RESET_VEC,
        nxt:  RESET_VEC + STEP1,
        nnx:  RESET_VEC + STEP2,
        upc:  '0,
        nupc: upc_t'(1)
    };

    cmd_t   cmd;
    act_e   act;
    state_t state_d;
    state_t state_q;

    logic [ADDR_W-1:0] cur_d;
    logic [ADDR_W-1:0] nxt_d;
    logic [ADDR_W-1:0] nnx_d;
    upc_t              upc_d;
    upc_t              nupc_d;

    assign cmd = '{load: cmd_load, retire: cmd_retire, ustep: cmd_ustep,
                   target: cmd_target, utarget: cmd_utarget};

    pc_seq_arbiter i_arb (
        .cmd (cmd),
        .act (act)
    );

    pc_seq_next #(
        .ADDR_W     (ADDR_W),
        .INSN_BYTES (INSN_BYTES)
    ) i_next (
        .act        (act),
        .do_target  (cmd.target),
        .do_utarget (cmd.utarget),
        .load_addr  (load_addr),
        .redir_addr (redir_addr),
        .ujmp_tgt   (ujmp_tgt),
        .cur_q      (state_q.cur),
        .nxt_q      (state_q.nxt),
        .nnx_q      (state_q.nnx),
        .upc_q      (state_q.upc),
        .nupc_q     (state_q.nupc),
        .cur_d      (cur_d),
        .nxt_d      (nxt_d),
        .nnx_d      (nnx_d),
        .upc_d      (upc_d),
        .nupc_d     (nupc_d)
    );

    always_comb begin
        state_d = '{cur: cur_d, nxt: nxt_d, nnx: nnx_d, upc: upc_d, nupc: nupc_d};
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= RST_STATE;
        else
            state_q <= state_d;
    end

    pc_seq_branch #(
        .ADDR_W     (ADDR_W),
        .INSN_BYTES (INSN_BYTES)
    ) i_branch (
        .cur_q     (state_q.cur),
        .nxt_q     (state_q.nxt),
        .nnx_q     (state_q.nnx),
        .upc_q     (state_q.upc),
        .nupc_q    (state_q.nupc),
        .branching (branching)
    );

    pc_seq_match #(
        .ADDR_W (ADDR_W)
    ) i_match (
        .cur_q       (state_q.cur),
        .nxt_q       (state_q.nxt),
        .nnx_q       (state_q.nnx),
        .upc_q       (state_q.upc),
        .nupc_q      (state_q.nupc),
        .cmp_cur     (cmp_cur),
        .cmp_nxt     (cmp_nxt),
        .cmp_nnx     (cmp_nnx),
        .cmp_upc     (cmp_upc),
        .cmp_nupc    (cmp_nupc),
        .state_match (state_match)
    );

    assign cur_addr = state_q.cur;
    assign cur_upc  = state_q.upc;

    AST_LOAD_STATE: assert property (@(posedge clk) disable iff (rst)
        cmd_load |=> (state_q.cur == $past(load_addr)) &&
                     (state_q.nxt == $past(load_addr) + STEP1) &&
                     (state_q.nnx == $past(load_addr) + STEP2) &&
                     (state_q.upc == '0) && (state_q.nupc == upc_t'(1))); // R1

    AST_USTEP_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cmd_load && !cmd_retire && cmd_ustep) |=>
            $stable(state_q.cur) && $stable(state_q.nxt) && $stable(state_q.nnx) &&
            (state_q.upc == $past(state_q.nupc))); // R3

    AST_RETIRE_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (!cmd_load && cmd_retire) |=>
            (state_q.cur == $past(state_q.nxt)) && (state_q.nxt == $past(state_q.nnx)) &&
            (state_q.upc == '0) && (state_q.nupc == upc_t'(1))); // R4

    AST_TARGET_KEEPS_FRONT: assert property (@(posedge clk) disable iff (rst)
        (!cmd_load && !cmd_retire && !cmd_ustep && cmd_target) |=>
            $stable(state_q.cur) && $stable(state_q.nxt) && $stable(state_q.upc)); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cmd_load && !cmd_retire && !cmd_ustep && !cmd_target && !cmd_utarget) |=>
            $stable(state_q)); // R10

endmodule

// File: tb/test_pc_delay_seq.sv
`timescale 1ns/1ps
module test_pc_delay_seq;

    localparam int    AW    = 32;
    localparam int    NVEC  = 18;
    localparam time   TCLK  = 20ns;

    // command bits: {load, retire, ustep, target, utarget}
    localparam logic [4:0] C_NONE = 5'b00000;
    localparam logic [4:0] C_LOAD = 5'b10000;
    localparam logic [4:0] C_RET  = 5'b01000;
    localparam logic [4:0] C_STEP = 5'b00100;
    localparam logic [4:0] C_TGT  = 5'b00010;
    localparam logic [4:0] C_UTGT = 5'b00001;

    typedef struct packed {
        logic [4:0]    cmd;
        logic [AW-1:0] addr;
        logic [15:0]   utgt;
        logic [AW-1:0] ecur;
        logic [AW-1:0] enxt;
        logic [AW-1:0] ennx;
        logic [15:0]   eupc;
        logic [15:0]   enupc;
        logic          ebr;
        logic [3:0]    req;
    } vec_t;

    localparam vec_t VECS [0:NVEC-1] = '{
        '{C_LOAD, 32'h100, 16'h0, 32'h100, 32'h104, 32'h108, 16'd0, 16'd1, 1'b0, 4'd1},   // R1
        '{C_STEP, 32'h0,   16'h0, 32'h100, 32'h104, 32'h108, 16'd1, 16'd2, 1'b0, 4'd3},   // R3
        '{C_STEP, 32'h0,   16'h0, 32'h100, 32'h104, 32'h108, 16'd2, 16'd3, 1'b0, 4'd3},   // R3
        '{C_RET,  32'h0,   16'h0, 32'h104, 32'h108, 32'h10C, 16'd0, 16'd1, 1'b0, 4'd4},   // R4
        '{C_TGT,  32'h200, 16'h0, 32'h104, 32'h108, 32'h200, 16'd0, 16'd1, 1'b1, 4'd5},   // R5 R6
        '{C_RET,  32'h0,   16'h0, 32'h108, 32'h200, 32'h204, 16'd0, 16'd1, 1'b1, 4'd6},   // R6
        '{C_RET,  32'h0,   16'h0, 32'h200, 32'h204, 32'h208, 16'd0, 16'd1, 1'b0, 4'd6},   // R6
        '{C_TGT,  32'h20C, 16'h0, 32'h200, 32'h204, 32'h20C, 16'd0, 16'd1, 1'b1, 4'd5},   // R5
        '{C_RET,  32'h0,   16'h0, 32'h204, 32'h20C, 32'h210, 16'd0, 16'd1, 1'b0, 4'd6},   // R6 skip
        '{C_UTGT, 32'h0,   16'd5, 32'h204, 32'h20C, 32'h210, 16'd0, 16'd5, 1'b1, 4'd7},   // R7
        '{C_STEP, 32'h0,   16'h0, 32'h204, 32'h20C, 32'h210, 16'd5, 16'd6, 1'b0, 4'd7},   // R7
        '{C_NONE, 32'h999, 16'd9, 32'h204, 32'h20C, 32'h210, 16'd5, 16'd6, 1'b0, 4'd10},  // R10
        '{5'b11100, 32'h300, 16'h0, 32'h300, 32'h304, 32'h308, 16'd0, 16'd1, 1'b0, 4'd9}, // R9
        '{5'b01100, 32'h0,   16'h0, 32'h304, 32'h308, 32'h30C, 16'd0, 16'd1, 1'b0, 4'd9}, // R9
        '{5'b00110, 32'h400, 16'h0, 32'h304, 32'h308, 32'h30C, 16'd1, 16'd2, 1'b0, 4'd9}, // R9
        '{5'b00011, 32'h500, 16'd9, 32'h304, 32'h308, 32'h500, 16'd1, 16'd9, 1'b1, 4'd5}, // R5
        '{C_LOAD, 32'hFFFF_FFFC, 16'h0, 32'hFFFF_FFFC, 32'h0, 32'h4, 16'd0, 16'd1, 1'b0, 4'd1}, // R1 wrap
        '{C_RET,  32'h0,   16'h0, 32'h0,   32'h4,   32'h8,   16'd0, 16'd1, 1'b0, 4'd4}    // R4
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_load = 1'b0, cmd_retire = 1'b0, cmd_ustep = 1'b0;
    logic          cmd_target = 1'b0, cmd_utarget = 1'b0;
    logic [AW-1:0] load_addr = '0, redir_addr = '0;
    logic [15:0]   ujmp_tgt = '0;
    logic [AW-1:0] cmp_cur = '0, cmp_nxt = '0, cmp_nnx = '0;
    logic [15:0]   cmp_upc = '0, cmp_nupc = '0;
    logic [AW-1:0] cur_addr;
    logic [15:0]   cur_upc;
    logic          branching;
    logic          state_match;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(TCLK/2) clk = ~clk;

    pc_delay_seq i_pc_delay_seq (
        .clk (clk), .rst (rst),
        .cmd_load (cmd_load), .cmd_retire (cmd_retire), .cmd_ustep (cmd_ustep),
        .cmd_target (cmd_target), .cmd_utarget (cmd_utarget),
        .load_addr (load_addr), .redir_addr (redir_addr), .ujmp_tgt (ujmp_tgt),
        .cmp_cur (cmp_cur), .cmp_nxt (cmp_nxt), .cmp_nnx (cmp_nnx),
        .cmp_upc (cmp_upc), .cmp_nupc (cmp_nupc),
        .cur_addr (cur_addr), .cur_upc (cur_upc),
        .branching (branching), .state_match (state_match)
    );

    task automatic set_cmd(input logic [4:0] c);
        {cmd_load, cmd_retire, cmd_ustep, cmd_target, cmd_utarget} = c;
    endtask

    // full-state check: outputs plus comparator against the expected fields
    task automatic check_state(input string tag, input logic [AW-1:0] ec, en, enn,
                               input logic [15:0] eu, enu, input logic eb);
        cmp_cur = ec; cmp_nxt = en; cmp_nnx = enn; cmp_upc = eu; cmp_nupc = enu;
        #1;
        n_run++;
        if (cur_addr !== ec || cur_upc !== eu || branching !== eb || state_match !== 1'b1) begin
            n_fail++;
            $display("FAIL %s: cur=%h upc=%0d br=%b match=%b expected cur=%h upc=%0d br=%b match=1",
                     tag, cur_addr, cur_upc, branching, state_match, ec, eu, eb);
        end
    endtask

    task automatic check_miss(input string tag);
        #1;
        n_run++;
        if (state_match !== 1'b0) begin
            n_fail++;
            $display("FAIL %s: state_match=%b expected 0", tag, state_match);
        end
    endtask

    initial begin
        #(TCLK * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R2: reset state
        repeat (3) @(posedge clk);
        #2;
        check_state("R2 reset state", 32'h1000, 32'h1004, 32'h1008, 16'd0, 16'd1, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            set_cmd(VECS[i].cmd);
            load_addr  = VECS[i].addr;
            redir_addr = VECS[i].addr;
            ujmp_tgt   = VECS[i].utgt;
            @(posedge clk);
            #2;
            check_state($sformatf("R%0d vector %0d", VECS[i].req, i),
                        VECS[i].ecur, VECS[i].enxt, VECS[i].ennx,
                        VECS[i].eupc, VECS[i].enupc, VECS[i].ebr);
        end
        @(negedge clk);
        set_cmd(C_NONE);

        // R8: any single differing field drops the match; state is 0,4,8,0,1
        #2;
        check_state("R8 baseline", 32'h0, 32'h4, 32'h8, 16'd0, 16'd1, 1'b0);
        cmp_cur = 32'h4;  check_miss("R8 current field");  cmp_cur = 32'h0;
        cmp_nxt = 32'h8;  check_miss("R8 following field"); cmp_nxt = 32'h4;
        cmp_nnx = 32'hC;  check_miss("R8 third field");     cmp_nnx = 32'h8;
        cmp_upc = 16'd1;  check_miss("R8 micro field");     cmp_upc = 16'd0;
        cmp_nupc = 16'd2; check_miss("R8 next-micro field"); cmp_nupc = 16'd1;

        // R2: reset beats a simultaneous load
        @(negedge clk);
        rst = 1'b1; set_cmd(C_LOAD); load_addr = 32'h700;
        @(posedge clk);
        #2;
        check_state("R2 reset over load", 32'h1000, 32'h1004, 32'h1008, 16'd0, 16'd1, 1'b0);
        @(negedge clk);
        rst = 1'b0; set_cmd(C_NONE);

        // R3: micro index wraps at 16 bits
        @(negedge clk);
        set_cmd(C_STEP);
        repeat (65534) @(posedge clk);
        @(negedge clk);
        set_cmd(C_NONE);
        check_state("R3 before wrap", 32'h1000, 32'h1004, 32'h1008, 16'hFFFE, 16'hFFFF, 1'b0);
        @(negedge clk);
        set_cmd(C_STEP);
        @(posedge clk);
        #2;
        check_state("R3 R7 wrap keeps sequence", 32'h1000, 32'h1004, 32'h1008,
                    16'hFFFF, 16'h0000, 1'b0);
        @(negedge clk);
        set_cmd(C_RET);
        @(posedge clk);
        #2;
        check_state("R4 retire after wrap", 32'h1004, 32'h1008, 32'h100C, 16'd0, 16'd1, 1'b0);
        @(negedge clk);
        set_cmd(C_NONE);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule